// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a 32-bit timer with a small register bank on a synchronous write / combinational read port. When counting is enabled, the counter steps down by one at the input clock rate divided by a 12-bit prescaler. While counting, a counter value equal to the compare register sets a sticky match flag. The flag can be gated onto an interrupt line.

When the counter reaches zero, the next tick either reloads it from the load register or wraps it to all ones, depending on a control bit. The counter can optionally be loaded when the timer is switched on. With the overwrite bit set, software can force the counter by writing the load register. A software reset returns the block to a known state and reports itself as busy for a fixed number of cycles. Software polls the busy bit until it clears.

The clock-source field, the output-pin mode and the four low-power gating bits are stored and read back. Only the clock-source field changes behaviour: a value of zero stops the count.

Top module: `dctmr_top`

## Requirements
- R1: After the hardware reset, control, status, load and compare read 0, the counter (offset 0x10) reads 0xFFFFFFFF, irq is 0, and an unmapped offset reads 0.
- R2: While counting, the counter decreases by one every (P+1) cycles, where P is control[15:4]. The first decrement lands P+1 cycles after the first clock edge that follows the enabling write.
- R3: When control bit 1 is set, the first clock edge after control bit 0 goes from 0 to 1 copies the load register (offset 0x8) into the counter. When control bit 1 is clear, that edge leaves the counter unchanged.
- R4: With control bit 3 set, a tick at count 0 reloads the counter from the load register.
- R5: With control bit 3 clear, a tick at count 0 sets the counter to 0xFFFFFFFF, and counting continues downward from there.
- R6: If the counter equals the compare register (offset 0xC) during a counting cycle, status bit 0 (offset 0x4) reads 1 from the next cycle on and stays set.
- R7: Writing status with bit 0 = 1 clears the flag. Writing status with bit 0 = 0 leaves it unchanged.
- R8: irq is 1 exactly when the flag is set and control bit 2 is 1.
- R9: When control bit 0 is 0, or control[25:24] is 0, the counter holds its value.
- R10: With control bit 17 set, a write to the load register also sets the counter to the written value. With bit 17 clear, the counter is unaffected by that write.
- R11: Writing control with bit 16 = 1 clears all control fields except control[25:24], clears the flag and sets the counter to 0xFFFFFFFF. Bit 16 then reads 1 for 4 cycles, and all bus writes during that time are ignored.
- R12: Control reads back bits 25:17 and 15:0 as written, and bits 31:26 read 0. Writes to the counter offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Compare-match interrupt |

## Verification
The assertions check the following on every cycle:
- the counter holds whenever no tick or load source is active;
- the two end-of-count outcomes;
- that a match while counting always sets the flag;
- that a write-one clear drops the flag when no match competes;
- that the reset-busy window never runs past its length;
- that irq never rises without the flag.

Only the bench scenarios can show the exact tick spacing for a given prescaler, the difference between enabling with and without the load, and which fields survive a software reset. They also show that writes during the busy window are lost, and how readback masks reserved bits.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;

    localparam int REG_W = 32;
    localparam int PSC_W = 12;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_LOAD = 'h08;
    localparam int OFS_CMP  = 'h0C;
    localparam int OFS_CNT  = 'h10;

    // control word, bit positions are software visible
    typedef struct packed {
        logic [5:0]       rsv_hi;
        logic [1:0]       clk_sel;
        logic [1:0]       pin_mode;
        logic             stop_en;
        logic             doze_en;
        logic             wait_en;
        logic             dbg_en;
        logic             ovw;
        logic             swr;
        logic [PSC_W-1:0] presc;
        logic             rld;
        logic             cmp_ie;
        logic             en_load;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bus(logic [REG_W-1:0] w);
        ctrl_t c;
        c        = ctrl_t'(w);
        c.rsv_hi = '0;
        c.swr    = 1'b0;
        return c;
    endfunction

    function automatic ctrl_t ctrl_after_swr(ctrl_t old);
        ctrl_t c;
        c         = '0;
        c.clk_sel = old.clk_sel;
        return c;
    endfunction

    function automatic logic clk_on(logic [1:0] s);
        return s != 2'd0;
    endfunction

endpackage

// File: rtl/dctmr_presc.sv
module dctmr_presc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pc;

    assign tick = run && (pc >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc <= '0;
        end else if (tick) begin
            pc <= '0;
        end else begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/dctmr_count.sv
module dctmr_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         swr_start,
    input  logic         ovw_load,
    input  logic [W-1:0] ovw_val,
    input  logic         start_load,
    input  logic         tick,
    input  logic         rld_mode,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    logic [W-1:0] at_zero;

    assign at_zero = rld_mode ? load_val : '1;

    always_ff @(posedge clk) begin
        if (rst || swr_start) begin
            cnt <= '1;
        end else if (ovw_load) begin
            cnt <= ovw_val;
        end else if (start_load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= (cnt == '0) ? at_zero : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dctmr_match.sv
module dctmr_match #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         swr_start,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         clr,
    output logic         flag
);
    always_ff @(posedge clk) begin
        if (rst || swr_start) begin
            flag <= 1'b0;
        end else if (run && cnt == cmp) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dctmr_top.sv
module dctmr_top
    import dctmr_pkg::*;
#(
    parameter int AW         = 5,
    parameter int SWR_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int SCW = $clog2(SWR_CYCLES + 1);

    ctrl_t            ctrl_q;
    ctrl_t            wr_ctrl;
    ctrl_t            rd_ctrl;
    logic [REG_W-1:0] load_q, cmp_q, cnt;
    logic [SCW-1:0]   swr_cnt;
    logic             swr_busy, en_q, run, tick, flag;
    logic             sel_ctrl, sel_stat, sel_load, sel_cmp, sel_cnt;
    logic             wr_ok, swr_start, ovw_load, start_load, stat_clr;

    assign wr_ctrl  = ctrl_t'(bus_wdata);
    assign sel_ctrl = bus_addr == AW'(OFS_CTRL);
    assign sel_stat = bus_addr == AW'(OFS_STAT);
    assign sel_load = bus_addr == AW'(OFS_LOAD);
    assign sel_cmp  = bus_addr == AW'(OFS_CMP);
    assign sel_cnt  = bus_addr == AW'(OFS_CNT);

    assign swr_busy   = swr_cnt != '0;
    assign wr_ok      = bus_we && !swr_busy;
    assign swr_start  = wr_ok && sel_ctrl && wr_ctrl.swr;
    assign ovw_load   = wr_ok && sel_load && ctrl_q.ovw;
    assign stat_clr   = wr_ok && sel_stat && bus_wdata[0];
    assign start_load = ctrl_q.en && !en_q && ctrl_q.en_load && !swr_busy;
    assign run        = ctrl_q.en && en_q && clk_on(ctrl_q.clk_sel) && !swr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            load_q  <= '0;
            cmp_q   <= '0;
            swr_cnt <= '0;
            en_q    <= 1'b0;
        end else begin
            en_q <= ctrl_q.en;
            if (swr_start) begin
                ctrl_q  <= ctrl_after_swr(ctrl_q);
                swr_cnt <= SCW'(SWR_CYCLES);
            end else begin
                if (swr_busy) begin
                    swr_cnt <= swr_cnt - 1'b1;
                end
                if (wr_ok && sel_ctrl) begin
                    ctrl_q <= ctrl_from_bus(bus_wdata);
                end
            end
            if (wr_ok && sel_load) begin
                load_q <= bus_wdata;
            end
            if (wr_ok && sel_cmp) begin
                cmp_q <= bus_wdata;
            end
        end
    end

    dctmr_presc #(.W(PSC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (ctrl_q.presc),
        .tick (tick)
    );

    dctmr_count #(.W(REG_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .swr_start  (swr_start),
        .ovw_load   (ovw_load),
        .ovw_val    (bus_wdata),
        .start_load (start_load),
        .tick       (tick),
        .rld_mode   (ctrl_q.rld),
        .load_val   (load_q),
        .cnt        (cnt)
    );

    dctmr_match #(.W(REG_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .swr_start (swr_start),
        .run       (run),
        .cnt       (cnt),
        .cmp       (cmp_q),
        .clr       (stat_clr),
        .flag      (flag)
    );

    always_comb begin
        rd_ctrl     = ctrl_q;
        rd_ctrl.swr = swr_busy;
        bus_rdata   = '0;
        if (sel_ctrl) bus_rdata = rd_ctrl;
        if (sel_stat) bus_rdata = REG_W'(flag);
        if (sel_load) bus_rdata = load_q;
        if (sel_cmp)  bus_rdata = cmp_q;
        if (sel_cnt)  bus_rdata = cnt;
    end

    assign irq = flag && ctrl_q.cmp_ie;
endmodule

// File: rtl/dctmr_chk.sv
module dctmr_chk #(
    parameter int W          = 32,
    parameter int SWR_CYCLES = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic [W-1:0] load,
    input logic         rld,
    input logic         flag,
    input logic         irq,
    input logic         clr,
    input logic         swr_start,
    input logic         ovw_load,
    input logic         start_load,
    input logic         swr_busy
);
    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !swr_busy) begin
            busy_len <= '0;
        end else if (busy_len != 8'hFF) begin
            busy_len <= busy_len + 1'b1;
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !swr_start && !ovw_load && !start_load) |=> $stable(cnt));

    // R4
    eoc_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '0 && rld && !swr_start && !ovw_load && !start_load)
        |=> cnt == $past(load));

    // R5
    eoc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == '0 && !rld && !swr_start && !ovw_load && !start_load)
        |=> cnt == '1);

    // R6
    match_set_chk: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == cmp && !swr_start) |=> flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(run && cnt == cmp) && !swr_start) |=> !flag);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !flag |-> !irq);

    // R11
    swr_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy_len <= 8'(SWR_CYCLES));
endmodule

bind dctmr_top dctmr_chk #(.W(dctmr_pkg::REG_W), .SWR_CYCLES(SWR_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .tick       (tick),
    .cnt        (cnt),
    .cmp        (cmp_q),
    .load       (load_q),
    .rld        (ctrl_q.rld),
    .flag       (flag),
    .irq        (irq),
    .clr        (stat_clr),
    .swr_start  (swr_start),
    .ovw_load   (ovw_load),
    .start_load (start_load),
    .swr_busy   (swr_busy)
);

// File: tb/dctmr_top_test.sv
module dctmr_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                           A_CMP = 5'h0C, A_CNT = 5'h10;

    always #5 clk = ~clk;

    dctmr_top uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] mk(bit en, bit enl, bit ie, bit rl,
                                       int psc, bit ovw, int cs);
        logic [31:0] v;
        v = '0;
        v[0] = en; v[1] = enl; v[2] = ie; v[3] = rl;
        v[15:4] = psc[11:0]; v[17] = ovw; v[25:24] = cs[1:0];
        return v;
    endfunction

    function automatic logic [31:0] exp_cnt(logic [31:0] ld, int m, int d, bit rl);
        logic [31:0] c;
        c = ld;
        for (int t = 0; t < (m - 1) / d; t++)
            c = (c == 0) ? (rl ? ld : 32'hFFFF_FFFF) : c - 1;
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; ends at the negedge after the write edge
    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 load", A_LOAD, 32'h0);
        rd_chk("R1 cmp", A_CMP, 32'h0);
        rd_chk("R1 cnt", A_CNT, 32'hFFFF_FFFF);
        rd_chk("R1 unmapped", 5'h14, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R3 enable without load, then R2 first tick
        wr(A_CTRL, mk(0,0,0,0,0,1,1));
        wr(A_LOAD, 32'd40);
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd9);
        wr(A_CTRL, mk(1,0,0,0,0,0,1));
        step(1); rd_chk("R3 no load on enable", A_CNT, 32'd40);
        step(1); rd_chk("R2 first tick", A_CNT, 32'd39);

        // R2 prescaler directed: divide by 3
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd50);
        wr(A_CTRL, mk(1,1,0,0,2,0,2));
        step(1); rd_chk("R3 load on enable", A_CNT, 32'd50);
        step(2); rd_chk("R2 before tick", A_CNT, 32'd50);
        step(1); rd_chk("R2 after tick", A_CNT, 32'd49);
        step(3); rd_chk("R2 second tick", A_CNT, 32'd48);

        // R2 R4 R5 random runs
        for (int i = 0; i < 30; i++) begin
            int ld = $urandom % 16;
            int d  = 1 + $urandom % 4;
            int m  = 1 + $urandom % 60;
            int cs = 1 + $urandom % 3;
            bit rl = 1'($urandom % 2);
            wr(A_CTRL, 32'h0);
            wr(A_LOAD, 32'(ld));
            wr(A_CTRL, mk(1,1,0,rl,d-1,0,cs));
            step(m);
            rd_chk("R2 random count", A_CNT, exp_cnt(32'(ld), m, d, rl));
        end

        // R9 disabled hold
        wr(A_CTRL, 32'h0);
        rd(A_CNT, held);
        step(5);
        rd_chk("R9 hold disabled", A_CNT, held);
        // R9 clock source off
        wr(A_CTRL, mk(1,0,0,0,0,0,0));
        step(6);
        rd_chk("R9 hold clock off", A_CNT, held);

        // R5 wrap
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, mk(1,1,0,0,0,0,1));
        step(4); rd_chk("R5 wrap", A_CNT, 32'hFFFF_FFFF);
        step(1); rd_chk("R5 after wrap", A_CNT, 32'hFFFF_FFFE);
        // R4 reload
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, mk(1,1,0,1,0,0,3));
        step(4); rd_chk("R4 reload", A_CNT, 32'd2);
        step(1); rd_chk("R4 after reload", A_CNT, 32'd1);

        // R6 match
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h1);
        wr(A_CMP, 32'd7);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, mk(1,1,1,0,0,0,1));
        step(4);
        rd_chk("R6 count at compare", A_CNT, 32'd7);
        rd_chk("R6 flag not yet", A_STAT, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        step(1);
        rd_chk("R6 flag set", A_STAT, 32'h1);
        check("R8 irq high", {31'b0, irq}, 32'h1);

        // R8 gating
        wr(A_CTRL, mk(0,0,0,0,0,0,1));
        rd_chk("R6 flag sticky", A_STAT, 32'h1);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(A_CTRL, mk(0,0,1,0,0,0,1));
        check("R8 irq unmasked", {31'b0, irq}, 32'h1);

        // R7 write-one-to-clear
        wr(A_STAT, 32'h0);
        rd_chk("R7 write zero keeps", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        rd_chk("R7 write one clears", A_STAT, 32'h0);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);

        // R6 rearm with compare equal to load
        wr(A_CMP, 32'd3);
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, mk(1,1,1,1,0,0,1));
        step(2);
        rd_chk("R6 flag on loaded value", A_STAT, 32'h1);

        // R11 software reset
        wr(A_CTRL, mk(0,0,1,1,5,0,2) | 32'h0060_0000);
        wr(A_CTRL, 32'h0001_0000);
        rd_chk("R11 ctrl busy", A_CTRL, 32'h0201_0000);
        rd_chk("R11 cnt preset", A_CNT, 32'hFFFF_FFFF);
        rd_chk("R11 flag cleared", A_STAT, 32'h0);
        wr(A_CMP, 32'hAA);
        rd_chk("R11 still busy", A_CTRL, 32'h0201_0000);
        step(2);
        rd_chk("R11 busy 4th cycle", A_CTRL, 32'h0201_0000);
        step(1);
        rd_chk("R11 done", A_CTRL, 32'h0200_0000);
        rd_chk("R11 write ignored", A_CMP, 32'd3);

        // R12 readback and read-only counter
        wr(A_CTRL, 32'hFFFE_FFF0);
        rd_chk("R12 ctrl readback", A_CTRL, 32'h03FE_FFF0);
        wr(A_CNT, 32'h0);
        rd_chk("R12 cnt read-only", A_CNT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0);

        // R10 overwrite
        wr(A_CTRL, mk(0,0,0,0,0,1,0));
        wr(A_LOAD, 32'h1234);
        rd_chk("R10 overwrite", A_CNT, 32'h1234);
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'h55);
        rd_chk("R10 no overwrite", A_CNT, 32'h1234);
        rd_chk("R10 load stored", A_LOAD, 32'h55);

        done = 1;
        summary();
        $finish;
    end
endmodule